// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the software-facing register file of one DMA channel. A simple 32-bit register port reads and writes a control/status word, a descriptor-address register and a debug register. The same port reads back, without writing, the six fields of the descriptor that the transfer engine is currently working on. Those fields reach the block as plain input buses.

The control/status word has three kinds of bits. A self-clearing reset bit wipes the word and the descriptor address. Two completion flags are cleared by writing a one to them. A fixed mask of plain bits takes whatever value is written. Writing the run bit from 0 to 1 produces a one-cycle start pulse for the engine. The engine uses dedicated inputs to report completion, to raise the interrupt and to halt. These inputs win over a software write to the same bits in the same cycle. The channel interrupt line follows the interrupt flag.

Top module: `dma_chan_regs`

## Requirements
- R1: While rst_n is low and after it rises, the status word, the descriptor address and the debug register read 0, and irq and start_pulse are low.
- R2: Offset 0x00 is the status word, 0x04 the descriptor address and 0x20 the debug register. A write to 0x04 or 0x20 stores the full 32-bit value, which reads back from the next cycle.
- R3: Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read the current info, source, destination, length, stride and next-pointer inputs in that order. Writes to them change nothing.
- R4: Any other offset, including a non-multiple of 4, reads 0. A write to it changes no register.
- R5: Writing a 1 to status bit 31 clears the whole status word and the descriptor address before the rest of the write is applied. Bit 31 always reads 0.
- R6: Writing a 1 to status bit 1 (done) clears it. Writing a 1 to status bit 2 (interrupt) clears it and drops irq.
- R7: Status bits in mask 0x30FF0001 take the written value. All other status bits (paused at bit 4, held at bit 5, error at bit 8 and the rest) keep their state unless a clear rule applies.
- R8: Writing status bit 30 (abort) has no effect, and bit 30 reads 0.
- R9: start_pulse is high for exactly the one cycle after the write edge, and only when status bit 0 (run) was 0 before that edge and is 1 after it.
- R10: eng_set_end sets bit 1, eng_set_int sets bit 2, and eng_halt clears bit 0 and sets bit 4 (paused). Each takes priority over a software write to the same bit in the same cycle.
- R11: irq equals status bit 2 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| eng_set_end | input | 1 | Engine: descriptor finished, set done flag |
| eng_set_int | input | 1 | Engine: raise the interrupt flag |
| eng_halt | input | 1 | Engine: chain finished, clear run and set paused |
| cur_info | input | 32 | Current descriptor info word |
| cur_src | input | 32 | Current source address |
| cur_dst | input | 32 | Current destination address |
| cur_len | input | 32 | Current remaining length |
| cur_stride | input | 32 | Current stride word |
| cur_next | input | 32 | Current next-descriptor pointer |
| start_pulse | output | 1 | One-cycle engine start request |
| irq | output | 1 | Channel interrupt line |

## Verification
A write or engine pulse takes effect at the rising edge where it is seen. From the cycle that follows, the stored value shows on reg_rdata and on irq. start_pulse is registered, so it is high in exactly that following cycle and low again one edge later. reg_rdata is combinational from reg_addr, so a read is valid in the same cycle the address is applied. The bench changes inputs on the falling edge and samples a short delay later in the low phase after the committing edge. It therefore sees every result in the cycle the result is due, and sees start_pulse before it drops again.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int DW = 32;

  // status word bit positions
  localparam int ST_RUN   = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_IRQ   = 2;
  localparam int ST_PAUSE = 4;
  localparam int ST_ABORT = 30;
  localparam int ST_CLR   = 31;

  // plain read/write bits of the status word
  localparam logic [DW-1:0] ST_PLAIN_MASK = 32'h30FF_0001;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_DESC   = 8'h04;
  localparam logic [7:0] OFS_INFO   = 8'h08;
  localparam logic [7:0] OFS_SRC    = 8'h0C;
  localparam logic [7:0] OFS_DST    = 8'h10;
  localparam logic [7:0] OFS_LEN    = 8'h14;
  localparam logic [7:0] OFS_STRIDE = 8'h18;
  localparam logic [7:0] OFS_NEXT   = 8'h1C;
  localparam logic [7:0] OFS_DBG    = 8'h20;

  // software write: wipe, then one-to-clear flags, then the plain bits
  function automatic logic [DW-1:0] ctrl_sw_apply(input logic [DW-1:0] cur,
                                                  input logic [DW-1:0] wd);
    logic [DW-1:0] v;
    v = cur;
    if (wd[ST_CLR])  v = '0;
    if (wd[ST_DONE]) v[ST_DONE] = 1'b0;
    if (wd[ST_IRQ])  v[ST_IRQ]  = 1'b0;
    v = (v & ~ST_PLAIN_MASK) | (wd & ST_PLAIN_MASK);
    return v;
  endfunction

  // engine updates, applied after software so that they win
  function automatic logic [DW-1:0] ctrl_eng_apply(input logic [DW-1:0] cur,
                                                   input logic set_end,
                                                   input logic set_int,
                                                   input logic halt);
    logic [DW-1:0] v;
    v = cur;
    if (halt) begin
      v[ST_RUN]   = 1'b0;
      v[ST_PAUSE] = 1'b1;
    end
    if (set_end) v[ST_DONE] = 1'b1;
    if (set_int) v[ST_IRQ]  = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/dma_ctrl_next.sv
module dma_ctrl_next
  import dma_chan_pkg::*;
(
  input  logic [DW-1:0] ctrl_q,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          eng_set_end,
  input  logic          eng_set_int,
  input  logic          eng_halt,
  output logic [DW-1:0] ctrl_d,
  output logic          start_evt,
  output logic          clr_desc
);

  logic [DW-1:0] after_sw;

  always_comb begin
    after_sw  = wr_ctrl ? ctrl_sw_apply(ctrl_q, wdata) : ctrl_q;
    ctrl_d    = ctrl_eng_apply(after_sw, eng_set_end, eng_set_int, eng_halt);
    start_evt = wr_ctrl && !ctrl_q[ST_RUN] && ctrl_d[ST_RUN];
    clr_desc  = wr_ctrl && wdata[ST_CLR];
  end

endmodule

// File: rtl/dma_reg_rdmux.sv
module dma_reg_rdmux
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     ctrl_q,
  input  logic [DW-1:0]     desc_q,
  input  logic [DW-1:0]     dbg_q,
  input  logic [DW-1:0]     cur_info,
  input  logic [DW-1:0]     cur_src,
  input  logic [DW-1:0]     cur_dst,
  input  logic [DW-1:0]     cur_len,
  input  logic [DW-1:0]     cur_stride,
  input  logic [DW-1:0]     cur_next,
  output logic [DW-1:0]     rdata
);

  always_comb begin
    rdata = '0;
    if      (addr == ADDR_W'(OFS_CTRL))   rdata = ctrl_q;
    else if (addr == ADDR_W'(OFS_DESC))   rdata = desc_q;
    else if (addr == ADDR_W'(OFS_INFO))   rdata = cur_info;
    else if (addr == ADDR_W'(OFS_SRC))    rdata = cur_src;
    else if (addr == ADDR_W'(OFS_DST))    rdata = cur_dst;
    else if (addr == ADDR_W'(OFS_LEN))    rdata = cur_len;
    else if (addr == ADDR_W'(OFS_STRIDE)) rdata = cur_stride;
    else if (addr == ADDR_W'(OFS_NEXT))   rdata = cur_next;
    else if (addr == ADDR_W'(OFS_DBG))    rdata = dbg_q;
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_set_end,
  input  logic              eng_set_int,
  input  logic              eng_halt,
  input  logic [31:0]       cur_info,
  input  logic [31:0]       cur_src,
  input  logic [31:0]       cur_dst,
  input  logic [31:0]       cur_len,
  input  logic [31:0]       cur_stride,
  input  logic [31:0]       cur_next,
  output logic              start_pulse,
  output logic              irq
);

  logic [DW-1:0] ctrl_q, ctrl_d, desc_q, dbg_q;
  logic          start_q, start_evt, clr_desc;
  logic          wr_ctrl, wr_desc, wr_dbg;

  assign wr_ctrl = reg_wen && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_desc = reg_wen && (reg_addr == ADDR_W'(OFS_DESC));
  assign wr_dbg  = reg_wen && (reg_addr == ADDR_W'(OFS_DBG));

  dma_ctrl_next u_next (
    .ctrl_q      (ctrl_q),
    .wr_ctrl     (wr_ctrl),
    .wdata       (reg_wdata),
    .eng_set_end (eng_set_end),
    .eng_set_int (eng_set_int),
    .eng_halt    (eng_halt),
    .ctrl_d      (ctrl_d),
    .start_evt   (start_evt),
    .clr_desc    (clr_desc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      desc_q  <= '0;
      dbg_q   <= '0;
      start_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      start_q <= start_evt;
      if (clr_desc)     desc_q <= '0;
      else if (wr_desc) desc_q <= reg_wdata;
      if (wr_dbg)       dbg_q  <= reg_wdata;
    end
  end

  dma_reg_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr       (reg_addr),
    .ctrl_q     (ctrl_q),
    .desc_q     (desc_q),
    .dbg_q      (dbg_q),
    .cur_info   (cur_info),
    .cur_src    (cur_src),
    .cur_dst    (cur_dst),
    .cur_len    (cur_len),
    .cur_stride (cur_stride),
    .cur_next   (cur_next),
    .rdata      (reg_rdata)
  );

  assign start_pulse = start_q;
  assign irq         = ctrl_q[ST_IRQ];

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              eng_set_end,
  input logic              eng_set_int,
  input logic              eng_halt,
  input logic              start_pulse,
  input logic              irq,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       desc_q
);

  logic ctrl_acc;
  assign ctrl_acc = reg_wen && (reg_addr == '0);

  // R5
  clr_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[31]);

  // R8
  abort_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[30]);

  // R5
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wen && (reg_addr == ADDR_W'(4))) && !(ctrl_acc && reg_wdata[31])
    |=> $stable(desc_q));

  // R6
  irq_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc && reg_wdata[2] && !eng_set_int |=> !irq);

  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R9
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ctrl_q[0]);

  // R9
  start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc && reg_wdata[0] && !ctrl_q[0] && !eng_halt |=> start_pulse);

  // R10
  eng_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_set_end |=> ctrl_q[1]);

  // R10
  eng_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_halt |=> (!ctrl_q[0] && ctrl_q[4]));

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_set_int |=> irq);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wen     (reg_wen),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .eng_set_end (eng_set_end),
  .eng_set_int (eng_set_int),
  .eng_halt    (eng_halt),
  .start_pulse (start_pulse),
  .irq         (irq),
  .ctrl_q      (ctrl_q),
  .desc_q      (desc_q)
);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;

  localparam int CLK_P = 10;

  localparam logic [31:0] V_INFO = 32'hA000_0011;
  localparam logic [31:0] V_SRC  = 32'hB000_0104;
  localparam logic [31:0] V_DST  = 32'hC000_0208;
  localparam logic [31:0] V_LEN  = 32'h0003_0040;
  localparam logic [31:0] V_STR  = 32'hFFF0_0010;
  localparam logic [31:0] V_NXT  = 32'hD000_0300;

  typedef struct packed {
    logic [7:0]  a;
    logic        w;
    logic [31:0] d;
    logic [31:0] e;
    logic        s;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{8'h04, 1'b1, 32'h0000_1000, 32'h0000_1000, 1'b0}, // R2 descriptor addr
    '{8'h20, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0}, // R2 debug
    '{8'h00, 1'b1, 32'h00FF_0000, 32'h00FF_0000, 1'b0}, // R7 plain bits
    '{8'h00, 1'b1, 32'hFFFF_FFFF, 32'h30FF_0001, 1'b1}, // R5 R7 R9 wipe + set
    '{8'h04, 1'b0, 32'h0,         32'h0,         1'b0}, // R5 desc cleared
    '{8'h00, 1'b1, 32'h0000_0001, 32'h0000_0001, 1'b0}, // R9 already running
    '{8'h00, 1'b1, 32'h4000_0000, 32'h0000_0000, 1'b0}, // R8 abort
    '{8'h08, 1'b1, 32'h1234_5678, V_INFO,        1'b0}, // R3
    '{8'h0C, 1'b1, 32'h1234_5678, V_SRC,         1'b0}, // R3
    '{8'h10, 1'b1, 32'h1234_5678, V_DST,         1'b0}, // R3
    '{8'h14, 1'b0, 32'h0,         V_LEN,         1'b0}, // R3
    '{8'h18, 1'b1, 32'h1234_5678, V_STR,         1'b0}, // R3
    '{8'h1C, 1'b0, 32'h0,         V_NXT,         1'b0}, // R3
    '{8'h24, 1'b1, 32'h5555_5555, 32'h0,         1'b0}, // R4 undefined
    '{8'h02, 1'b1, 32'h5555_5555, 32'h0,         1'b0}, // R4 unaligned
    '{8'h20, 1'b0, 32'h0,         32'hDEAD_BEEF, 1'b0}, // R4 debug untouched
    '{8'h00, 1'b1, 32'h0000_0001, 32'h0000_0001, 1'b1}  // R9 rise
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_set_end = 1'b0, eng_set_int = 1'b0, eng_halt = 1'b0;
  logic        start_pulse, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_regs #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_set_end(eng_set_end), .eng_set_int(eng_set_int), .eng_halt(eng_halt),
    .cur_info(V_INFO), .cur_src(V_SRC), .cur_dst(V_DST), .cur_len(V_LEN),
    .cur_stride(V_STR), .cur_next(V_NXT),
    .start_pulse(start_pulse), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one cycle: inputs set at negedge, committed at posedge, sampled after next negedge
  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input logic se, input logic si, input logic h);
    @(negedge clk);
    reg_addr = a; reg_wen = w; reg_wdata = d;
    eng_set_end = se; eng_set_int = si; eng_halt = h;
    @(negedge clk);
    reg_wen = 1'b0; eng_set_end = 1'b0; eng_set_int = 1'b0; eng_halt = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    #(CLK_P * 3 + 1);
    // R1 reset state while held
    rd(8'h00, v); check("R1 status in reset", v, 32'h0);
    check("R1 irq/start in reset", {30'b0, irq, start_pulse}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    rd(8'h04, v); check("R1 desc after reset", v, 32'h0);
    rd(8'h20, v); check("R1 debug after reset", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].a, VEC[i].w, VEC[i].d, 1'b0, 1'b0, 1'b0);
      check($sformatf("R2-table vec %0d start", i), {31'b0, start_pulse}, {31'b0, VEC[i].s});
      rd(VEC[i].a, v);
      check($sformatf("R3-table vec %0d rdata", i), v, VEC[i].e);
    end

    // R10 R11: engine raises done and interrupt (run still 1)
    step(8'h00, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    rd(8'h00, v); check("R10 engine set done+int", v, 32'h0000_0007);
    check("R11 irq high", {31'b0, irq}, 32'h1);

    // R6 clear done only
    step(8'h00, 1'b1, 32'h0000_0002, 1'b0, 1'b0, 1'b0);
    rd(8'h00, v); check("R6 done w1c", v, 32'h0000_0004);
    check("R11 irq still high", {31'b0, irq}, 32'h1);

    // R6 clear interrupt
    step(8'h00, 1'b1, 32'h0000_0004, 1'b0, 1'b0, 1'b0);
    rd(8'h00, v); check("R6 int w1c", v, 32'h0);
    check("R6 irq low", {31'b0, irq}, 32'h0);

    // R10 engine set beats software clear of done
    step(8'h00, 1'b1, 32'h0000_0002, 1'b1, 1'b0, 1'b0);
    rd(8'h00, v); check("R10 done priority", v, 32'h0000_0002);

    // R10 halt beats a run write; no start
    step(8'h00, 1'b1, 32'h0000_0001, 1'b0, 1'b0, 1'b1);
    check("R9 no start on halt", {31'b0, start_pulse}, 32'h0);
    rd(8'h00, v); check("R10 halt priority", v, 32'h0000_0012);

    // R7 paused and done keep state across a plain write
    step(8'h00, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    rd(8'h00, v); check("R7 non-mask bits held", v, 32'h0000_0012);

    // R5 wipe clears paused and done
    step(8'h00, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    rd(8'h00, v); check("R5 wipe", v, 32'h0);

    // R9 pulse lasts one cycle only
    step(8'h00, 1'b1, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    check("R9 start high", {31'b0, start_pulse}, 32'h1);
    @(negedge clk); #1;
    check("R9 start one cycle", {31'b0, start_pulse}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule